// File: doc/BRIEF.md
# Pipelined Array Multiply-Add Unit

This block takes two unsigned operands `a` and `x` and an unsigned addend `y`, all N bits wide, and returns the 2N-bit value a·x + y. Inside, it is a one-sided array of carry-save rows, one row per bit of `x`. Row k adds the partial product (`a` gated by bit k of `x`) to a running sum vector and a running carry vector. The top row has a third input that a plain multiplier would tie to zero; here it takes the addend `y`. A register stage follows every row. At each row the least significant sum bit is final, so it leaves the array there and rides a shift field down the pipeline with its operation. After the last row, one carry-propagate adder merges the sum and carry vectors into the upper N bits of the result, and a register holds the result.

An operation is accepted on any cycle with `in_vld` high, and several operations may be in flight at once. Each result appears a fixed number of cycles later, in issue order, marked by a one-cycle pulse on `out_vld`. The result is never wider than 2N bits, because (2^N−1)² + (2^N−1) = 2^(2N) − 2^N.

Top module: `arr_muladd`

## Requirements
- R1: When `out_vld` is high, `out_res` equals the exact unsigned value `in_a`·`in_x` + `in_y` of the operation it belongs to, with no truncation.
- R2: `out_vld` rises exactly N+1 clock cycles after the cycle in which `in_vld` was sampled high. With the default N=8, that is 9 cycles.
- R3: Operations issued on consecutive cycles are all accepted. Their results leave on consecutive cycles in the order of issue.
- R4: Each accepted operation produces exactly one cycle of `out_vld`. Operand values presented while `in_vld` is low produce no result and do not alter any other result.
- R5: A synchronous reset (`rst` high at a clock edge) clears every pipeline valid bit and clears `out_res` to 0. An operation in flight at reset never produces `out_vld`.
- R6: While `out_vld` is low, `out_res` keeps the last result delivered (or 0 after reset).
- R7: With all operands at their maximum (2^N−1), the result is 2^(2N) − 2^N, which is 65280 for N=8. With `in_a` and `in_x` at maximum and `in_y` = 0, the result is 65025.
- R8: With `in_x` = 0 or `in_a` = 0, the result equals `in_y`, which shows the addend path on its own. With `in_y` = 0, the result is the plain product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operands valid this cycle |
| in_a | input | N | Multiplicand |
| in_x | input | N | Multiplier; bit k drives carry-save row k |
| in_y | input | N | Addend, fed into the top row |
| out_vld | output | 1 | Result valid pulse |
| out_res | output | 2N | a·x + y, held between results |

## Verification
The bench targets the extremes of the value range. All-ones operands expose a final adder that drops a carry, or a retired low bit that lands in the wrong position, as a wrong upper or lower byte of 65280. A zero multiplier, or a zero multiplicand with a nonzero addend, returns nothing but `y`. A design that fed the addend into the wrong row, or that lost it, would return 0 or a shifted value in that case. Back-to-back and gapped streams, with junk operands driven on idle cycles, would show a misaligned shift field or valid chain as results that are swapped, duplicated or early. A reset pulse in the middle of a stream would show a valid bit that survives reset as a stray `out_vld`.

// File: rtl/amu_pkg.sv
package amu_pkg;

    // Register stages from operand capture to result: one per carry-save row
    // plus one for the resolving adder.
    function automatic int amu_latency(input int rows);
        return rows + 1;
    endfunction

    // Width of the full product-plus-addend result.
    function automatic int amu_res_width(input int n);
        return 2 * n;
    endfunction

endpackage

// File: rtl/amu_csa_row.sv
module amu_csa_row #(
    parameter int N = 8
) (
    input  logic [N-1:0] sum_i,
    input  logic [N-1:0] car_i,
    input  logic [N-1:0] mcand,
    input  logic         mbit,
    output logic [N-1:0] sum_o,
    output logic [N-1:0] car_o,
    output logic         bit_o
);
    logic [N-1:0] pp;
    logic [N-1:0] s_full;

    always_comb begin
        pp     = mcand & {N{mbit}};
        s_full = sum_i ^ car_i ^ pp;
        car_o  = (sum_i & car_i) | (sum_i & pp) | (car_i & pp);
        bit_o  = s_full[0];
        // The remaining sum drops one weight; the carries already sit one
        // weight up, so they line up with the shifted sum unchanged.
        sum_o  = {1'b0, s_full[N-1:1]};
    end
endmodule

// File: rtl/amu_cpa.sv
module amu_cpa #(
    parameter int N = 8
) (
    input  logic [N-1:0] sum_i,
    input  logic [N-1:0] car_i,
    output logic [N-1:0] hi_o
);
    // The residual value is below 2^N, so an N-bit sum is exact.
    always_comb begin
        hi_o = sum_i + car_i;
    end
endmodule

// File: rtl/arr_muladd.sv
module arr_muladd
    import amu_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [N-1:0]     in_a,
    input  logic [N-1:0]     in_x,
    input  logic [N-1:0]     in_y,
    output logic             out_vld,
    output logic [2*N-1:0]   out_res
);
    localparam int ROWS = N;
    localparam int RW   = amu_res_width(N);

    typedef struct packed {
        logic         vld;
        logic [N-1:0] s;
        logic [N-1:0] c;
        logic [N-1:0] a;
        logic [N-1:0] x;
        logic [N-1:0] lo;
    } stage_t;

    typedef struct packed {
        logic          vld;
        logic [RW-1:0] val;
    } res_t;

    stage_t st_d [ROWS];
    stage_t st_q [ROWS];
    res_t   res_d;
    res_t   res_q;

    logic [N-1:0] row_s [ROWS];
    logic [N-1:0] row_c [ROWS];
    logic         row_b [ROWS];
    logic [N-1:0] hi_sum;

    genvar k;
    generate
        for (k = 0; k < ROWS; k++) begin : g_row
            if (k == 0) begin : g_top
                // Top row: addend occupies the otherwise-zero input.
                amu_csa_row #(.N(N)) u_row (
                    .sum_i (in_y),
                    .car_i ('0),
                    .mcand (in_a),
                    .mbit  (in_x[0]),
                    .sum_o (row_s[k]),
                    .car_o (row_c[k]),
                    .bit_o (row_b[k])
                );
            end else begin : g_mid
                amu_csa_row #(.N(N)) u_row (
                    .sum_i (st_q[k-1].s),
                    .car_i (st_q[k-1].c),
                    .mcand (st_q[k-1].a),
                    .mbit  (st_q[k-1].x[k]),
                    .sum_o (row_s[k]),
                    .car_o (row_c[k]),
                    .bit_o (row_b[k])
                );
            end
        end
    endgenerate

    amu_cpa #(.N(N)) u_cpa (
        .sum_i (st_q[ROWS-1].s),
        .car_i (st_q[ROWS-1].c),
        .hi_o  (hi_sum)
    );

    always_comb begin
        for (int i = 0; i < ROWS; i++) begin
            if (i == 0) begin
                st_d[i].vld = rst ? 1'b0 : in_vld;
                st_d[i].a   = in_a;
                st_d[i].x   = in_x;
                st_d[i].lo  = '0;
            end else begin
                st_d[i].vld = rst ? 1'b0 : st_q[i-1].vld;
                st_d[i].a   = st_q[i-1].a;
                st_d[i].x   = st_q[i-1].x;
                st_d[i].lo  = st_q[i-1].lo;
            end
            st_d[i].s     = row_s[i];
            st_d[i].c     = row_c[i];
            st_d[i].lo[i] = row_b[i];
        end

        if (rst) begin
            res_d.vld = 1'b0;
            res_d.val = '0;
        end else begin
            res_d.vld = st_q[ROWS-1].vld;
            res_d.val = st_q[ROWS-1].vld ? {hi_sum, st_q[ROWS-1].lo} : res_q.val;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ROWS; i++) begin
            st_q[i] <= st_d[i];
        end
        res_q <= res_d;
    end

    assign out_vld = res_q.vld;
    assign out_res = res_q.val;

endmodule

// File: rtl/amu_chk.sv
module amu_chk
    import amu_pkg::*;
#(
    parameter int N = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_vld,
    input logic [N-1:0]     in_a,
    input logic [N-1:0]     in_x,
    input logic [N-1:0]     in_y,
    input logic             out_vld,
    input logic [2*N-1:0]   out_res
);
    localparam int LAT = amu_latency(N);
    localparam int RW  = amu_res_width(N);

    logic [LAT-1:0] vpipe;
    logic [RW-1:0]  epipe [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            vpipe <= '0;
        end else begin
            vpipe <= {vpipe[LAT-2:0], in_vld};
        end
        epipe[0] <= RW'(in_a) * RW'(in_x) + RW'(in_y);
        for (int i = 1; i < LAT; i++) begin
            epipe[i] <= epipe[i-1];
        end
    end

    // R2
    latency_match_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld == vpipe[LAT-1]);

    // R1
    result_value_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> out_res == epipe[LAT-1]);

    // R5
    reset_flush_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_vld);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_vld && !$past(rst)) |-> $stable(out_res));

endmodule

bind arr_muladd amu_chk #(.N(N)) u_chk (.*);

// File: tb/arr_muladd_bench.sv
module arr_muladd_bench;
    localparam int N   = 8;
    localparam int LAT = N + 1;
    localparam int NV  = 12;

    // {a, x, y, expected}
    localparam logic [39:0] VEC [NV] = '{
        {8'd0,   8'd0,   8'd0,   16'd0},
        {8'd255, 8'd255, 8'd255, 16'd65280},
        {8'd255, 8'd255, 8'd0,   16'd65025},
        {8'd1,   8'd1,   8'd0,   16'd1},
        {8'd0,   8'd77,  8'd200, 16'd200},
        {8'd12,  8'd0,   8'd99,  16'd99},
        {8'd13,  8'd11,  8'd7,   16'd150},
        {8'd100, 8'd200, 8'd55,  16'd20055},
        {8'd128, 8'd128, 8'd0,   16'd16384},
        {8'd170, 8'd85,  8'd255, 16'd14705},
        {8'd3,   8'd255, 8'd254, 16'd1019},
        {8'd255, 8'd1,   8'd255, 16'd510}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_vld = 1'b0;
    logic [N-1:0]  in_a = '0;
    logic [N-1:0]  in_x = '0;
    logic [N-1:0]  in_y = '0;
    logic          out_vld;
    logic [2*N-1:0] out_res;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    arr_muladd #(.N(N)) u_arr_muladd (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_a    (in_a),
        .in_x    (in_x),
        .in_y    (in_y),
        .out_vld (out_vld),
        .out_res (out_res)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic [N-1:0] a, input logic [N-1:0] x,
                         input logic [N-1:0] y);
        in_vld = v;
        in_a   = a;
        in_x   = x;
        in_y   = y;
    endtask

    task automatic run_tests();
        // Reset state: R5, R6
        repeat (4) @(negedge clk);
        chk("R5 reset out_vld", 32'(out_vld), 0);
        chk("R6 reset out_res", 32'(out_res), 0);
        rst = 1'b0;

        // Back-to-back stream over the vector table: R1 R2 R3 R4 R7 R8
        for (int c = 0; c < NV + LAT + 1; c++) begin
            @(negedge clk);
            if (c >= LAT && c - LAT < NV) begin
                chk("R2/R3 stream out_vld", 32'(out_vld), 1);
                chk("R1/R7/R8 stream value", 32'(out_res), 32'(VEC[c-LAT][15:0]));
            end else begin
                chk("R4 stream idle out_vld", 32'(out_vld), 0);
            end
            if (c < NV) drive(1'b1, VEC[c][39:32], VEC[c][31:24], VEC[c][23:16]);
            else        drive(1'b0, '0, '0, '0);
        end

        // Hold between results: R6
        repeat (3) @(negedge clk);
        chk("R6 hold out_vld", 32'(out_vld), 0);
        chk("R6 hold out_res", 32'(out_res), 32'(VEC[NV-1][15:0]));

        // Gapped stream with junk on idle cycles: R4
        for (int c = 0; c < 8 + LAT + 2; c++) begin
            @(negedge clk);
            if (c >= LAT && (c - LAT) % 2 == 0 && (c - LAT) / 2 < 4) begin
                chk("R4 gap out_vld", 32'(out_vld), 1);
                chk("R4 gap value", 32'(out_res), 32'(VEC[6 + (c-LAT)/2][15:0]));
            end else begin
                chk("R4 gap idle out_vld", 32'(out_vld), 0);
            end
            if (c < 8 && c % 2 == 0)
                drive(1'b1, VEC[6+c/2][39:32], VEC[6+c/2][31:24], VEC[6+c/2][23:16]);
            else
                drive(1'b0, 8'hFF, 8'hFF, 8'hFF);
        end

        // Reset with operations in flight: R5
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            drive(1'b1, VEC[1+c][39:32], VEC[1+c][31:24], VEC[1+c][23:16]);
        end
        @(negedge clk);
        drive(1'b0, '0, '0, '0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < LAT + 3; c++) begin
            @(negedge clk);
            chk("R5 flushed out_vld", 32'(out_vld), 0);
            chk("R5 flushed out_res", 32'(out_res), 0);
        end

        // Recovery after reset, single op: R2 R1
        drive(1'b1, VEC[9][39:32], VEC[9][31:24], VEC[9][23:16]);
        @(negedge clk);
        drive(1'b0, '0, '0, '0);
        repeat (LAT - 2) @(negedge clk);
        chk("R2 early out_vld", 32'(out_vld), 0);
        @(negedge clk);
        chk("R2 single out_vld", 32'(out_vld), 1);
        chk("R1 single value", 32'(out_res), 32'(VEC[9][15:0]));
        @(negedge clk);
        chk("R4 single pulse", 32'(out_vld), 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule